// File: doc/BRIEF.md
# Debug Trigger Register Bank

This block keeps the configuration of a small, parameterized set of address-match debug triggers. Software reaches them through a control-register style port. One register picks the active trigger. A second register holds that trigger's packed control word, and a third holds its comparison data word. A fourth data register is present but always reads as zero. The block does not compare addresses itself. It tells the memory unit, through three summary flags, whether any trigger watches instruction fetches, loads or stores. It also raises a one-cycle pulse whenever a control word changes, so that cached translation or match state downstream can be flushed.

A trigger can be locked to debug mode. While its lock bit is set, neither of its data registers can be changed unless the debug-mode input is high. When a control word asks for an execute match, the stored timing bit is forced to zero. A write to the select register that names a trigger that does not exist is dropped.

Top module: `trig_bank`

## Requirements
- R1: After reset the select register reads 0. Every trigger's control word reads with the type field (top four bits) equal to 2 and all other bits 0. Every data word reads 0, all three watch flags are 0 and `trigUpdated` is 0.
- R2: A write to the select register (address BASE_ADDR+0) is stored only when the written value is less than NUM_TRIG. Otherwise the select register keeps its previous value.
- R3: A control write (address BASE_ADDR+1) stores the writable fields of the selected trigger. The writable fields are: lock bit at XLEN-5, select 19, timing 18, action 17:12, chain 11, match 10:7, mode enables 6:3, execute 2, store 1, load 0. A read returns those fields with type 2 in bits XLEN-1:XLEN-4 and zeros in the maskmax field (XLEN-6:XLEN-11), in bit 20 and in all other bits.
- R4: When a stored control word has execute (bit 2) set, its timing bit (bit 18) is stored as 0 whatever was written.
- R5: A write to the control word or the data word of a trigger whose lock bit is set is dropped while `debugMode` is 0. The same write is accepted while `debugMode` is 1.
- R6: A data write (address BASE_ADDR+2) stores the full XLEN-bit value for the selected trigger, and a read returns it.
- R7: `watchFetch`, `watchLoad` and `watchStore` equal the OR across all triggers of the stored execute, load and store bits. They reflect a control write from the clock edge that stores it.
- R8: `trigUpdated` is high for exactly the cycle after each accepted control write and is low otherwise.
- R9: Reads of BASE_ADDR+3 and of any address outside the four registers return 0. Writes to those addresses change no register.
- R10: A control or data write changes only the trigger named by the select register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csrAddr | input | 12 | Register address |
| csrWdata | input | XLEN | Write data |
| csrWe | input | 1 | Write enable, sampled at the rising edge |
| csrRdata | output | XLEN | Combinational read data for csrAddr |
| debugMode | input | 1 | High while the hart is in debug mode; unlocks locked triggers |
| watchFetch | output | 1 | Some trigger matches fetches |
| watchLoad | output | 1 | Some trigger matches loads |
| watchStore | output | 1 | Some trigger matches stores |
| trigUpdated | output | 1 | One-cycle pulse after an accepted control write |

## Verification
The bench uses the defaults XLEN=32 and NUM_TRIG=4, so the select register is two bits wide. Random select writes drawn from 0..7, plus the all-ones word, therefore hit both the stored and the dropped case about equally often. Four triggers make it possible to check that the watch flags are an OR of independent triggers, not a copy of the selected one. Random control words set the lock bit about half the time and the debug-mode input is random, so locked-and-dropped writes and unlocked writes are interleaved across every trigger.

// File: rtl/trig_bank_pkg.sv
package trig_bank_pkg;

  localparam logic [3:0] TYPE_ADDR_MATCH = 4'd2;

  typedef struct packed {
    logic       dmode;
    logic       selData;
    logic       timing;
    logic [5:0] action;
    logic       chain;
    logic [3:0] matchKind;
    logic [3:0] modeEn;
    logic       execute;
    logic       store;
    logic       load;
  } trigCfg_t;

  typedef struct packed {
    logic selWr;
    logic cfgWr;
    logic data2Wr;
  } trigStrobe_t;

  typedef enum logic [1:0] {
    RD_ZERO  = 2'd0,
    RD_SEL   = 2'd1,
    RD_CFG   = 2'd2,
    RD_DATA2 = 2'd3
  } rdSrc_t;

  // Build the architectural control word from the stored fields.
  function automatic logic [63:0] packCfg(trigCfg_t c, int xlen);
    logic [63:0] w;
    w = 64'(TYPE_ADDR_MATCH) << (xlen - 4);
    w = w | (64'(c.dmode) << (xlen - 5));
    w[19]    = c.selData;
    w[18]    = c.timing;
    w[17:12] = c.action;
    w[11]    = c.chain;
    w[10:7]  = c.matchKind;
    w[6:3]   = c.modeEn;
    w[2]     = c.execute;
    w[1]     = c.store;
    w[0]     = c.load;
    return w;
  endfunction

  // Extract the writable fields; an execute match forces timing low.
  function automatic trigCfg_t unpackCfg(logic [63:0] w, int xlen);
    trigCfg_t c;
    c.dmode     = w[xlen - 5];
    c.selData   = w[19];
    c.timing    = w[2] ? 1'b0 : w[18];
    c.action    = w[17:12];
    c.chain     = w[11];
    c.matchKind = w[10:7];
    c.modeEn    = w[6:3];
    c.execute   = w[2];
    c.store     = w[1];
    c.load      = w[0];
    return c;
  endfunction

endpackage

// File: rtl/trig_ctrl.sv
module trig_ctrl
  import trig_bank_pkg::*;
#(
  parameter int          XLEN      = 32,
  parameter int          NUM_TRIG  = 4,
  parameter logic [11:0] BASE_ADDR = 12'h7A0
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [11:0]     csrAddr,
  input  logic [XLEN-1:0] csrWdata,
  input  logic            csrWe,
  input  logic            debugMode,
  input  logic            selLocked,
  output trigStrobe_t     stb,
  output rdSrc_t          rdSrc,
  output logic            updPulse
);
  localparam logic [11:0] ADDR_SEL   = BASE_ADDR;
  localparam logic [11:0] ADDR_CFG   = BASE_ADDR + 12'd1;
  localparam logic [11:0] ADDR_DATA2 = BASE_ADDR + 12'd2;
  localparam logic [XLEN-1:0] TRIG_LIMIT = XLEN'(NUM_TRIG);

  logic writeOpen;

  always_comb begin
    writeOpen   = !selLocked || debugMode;
    stb.selWr   = csrWe && (csrAddr == ADDR_SEL) && (csrWdata < TRIG_LIMIT);
    stb.cfgWr   = csrWe && (csrAddr == ADDR_CFG) && writeOpen;
    stb.data2Wr = csrWe && (csrAddr == ADDR_DATA2) && writeOpen;
  end

  always_comb begin
    unique case (csrAddr)
      ADDR_SEL:   rdSrc = RD_SEL;
      ADDR_CFG:   rdSrc = RD_CFG;
      ADDR_DATA2: rdSrc = RD_DATA2;
      default:    rdSrc = RD_ZERO;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) updPulse <= 1'b0;
    else       updPulse <= stb.cfgWr;
  end

endmodule

// File: rtl/trig_dp.sv
module trig_dp
  import trig_bank_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int NUM_TRIG = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [XLEN-1:0] csrWdata,
  input  trigStrobe_t     stb,
  input  rdSrc_t          rdSrc,
  output logic            selLocked,
  output logic [XLEN-1:0] csrRdata,
  output logic            watchFetch,
  output logic            watchLoad,
  output logic            watchStore
);
  localparam int SEL_W = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1;

  logic [SEL_W-1:0] selReg;
  trigCfg_t         cfgReg   [NUM_TRIG];
  logic [XLEN-1:0]  data2Reg [NUM_TRIG];
  trigCfg_t         newCfg;
  logic [63:0]      cfgWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          selReg <= '0;
    else if (stb.selWr) selReg <= csrWdata[SEL_W-1:0];
  end

  always_comb newCfg = unpackCfg(64'(csrWdata), XLEN);

  for (genvar t = 0; t < NUM_TRIG; t++) begin : g_trig
    logic hit;
    assign hit = (32'(selReg) == t);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cfgReg[t]   <= '0;
        data2Reg[t] <= '0;
      end else begin
        if (stb.cfgWr && hit)   cfgReg[t]   <= newCfg;
        if (stb.data2Wr && hit) data2Reg[t] <= csrWdata;
      end
    end
  end

  always_comb begin
    selLocked = 1'b0;
    for (int t = 0; t < NUM_TRIG; t++)
      if (32'(selReg) == t) selLocked = cfgReg[t].dmode;
  end

  always_comb begin
    watchFetch = 1'b0;
    watchLoad  = 1'b0;
    watchStore = 1'b0;
    for (int t = 0; t < NUM_TRIG; t++) begin
      watchFetch = watchFetch | cfgReg[t].execute;
      watchLoad  = watchLoad  | cfgReg[t].load;
      watchStore = watchStore | cfgReg[t].store;
    end
  end

  always_comb begin
    cfgWord = '0;
    for (int t = 0; t < NUM_TRIG; t++)
      if (32'(selReg) == t) cfgWord = packCfg(cfgReg[t], XLEN);
  end

  always_comb begin
    csrRdata = '0;
    unique case (rdSrc)
      RD_SEL:   csrRdata = XLEN'(selReg);
      RD_CFG:   csrRdata = cfgWord[XLEN-1:0];
      RD_DATA2: begin
        for (int t = 0; t < NUM_TRIG; t++)
          if (32'(selReg) == t) csrRdata = data2Reg[t];
      end
      default:  csrRdata = '0;
    endcase
  end

endmodule

// File: rtl/trig_bank.sv
module trig_bank
  import trig_bank_pkg::*;
#(
  parameter int          XLEN      = 32,
  parameter int          NUM_TRIG  = 4,
  parameter logic [11:0] BASE_ADDR = 12'h7A0
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [11:0]     csrAddr,
  input  logic [XLEN-1:0] csrWdata,
  input  logic            csrWe,
  output logic [XLEN-1:0] csrRdata,
  input  logic            debugMode,
  output logic            watchFetch,
  output logic            watchLoad,
  output logic            watchStore,
  output logic            trigUpdated
);
  trigStrobe_t stb;
  rdSrc_t      rdSrc;
  logic        selLocked;

  trig_ctrl #(.XLEN(XLEN), .NUM_TRIG(NUM_TRIG), .BASE_ADDR(BASE_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .csrAddr(csrAddr), .csrWdata(csrWdata),
    .csrWe(csrWe), .debugMode(debugMode), .selLocked(selLocked),
    .stb(stb), .rdSrc(rdSrc), .updPulse(trigUpdated)
  );

  trig_dp #(.XLEN(XLEN), .NUM_TRIG(NUM_TRIG)) u_dp (
    .clk(clk), .rstN(rstN), .csrWdata(csrWdata), .stb(stb), .rdSrc(rdSrc),
    .selLocked(selLocked), .csrRdata(csrRdata), .watchFetch(watchFetch),
    .watchLoad(watchLoad), .watchStore(watchStore)
  );

endmodule

// File: rtl/trig_bank_chk.sv
module trig_bank_chk #(
  parameter int          XLEN      = 32,
  parameter int          NUM_TRIG  = 4,
  parameter logic [11:0] BASE_ADDR = 12'h7A0
) (
  input logic            clk,
  input logic            rstN,
  input logic [11:0]     csrAddr,
  input logic            csrWe,
  input logic [XLEN-1:0] csrRdata,
  input logic            watchFetch,
  input logic            watchLoad,
  input logic            watchStore,
  input logic            trigUpdated
);
  localparam logic [11:0] A_SEL = BASE_ADDR;
  localparam logic [11:0] A_CFG = BASE_ADDR + 12'd1;
  localparam logic [11:0] A_D3  = BASE_ADDR + 12'd3;

  p_sel_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    (csrAddr == A_SEL) |-> (csrRdata < XLEN'(NUM_TRIG)));

  p_type_field_r1: assert property (@(posedge clk) disable iff (!rstN)
    (csrAddr == A_CFG) |-> (csrRdata[XLEN-1 -: 4] == 4'd2));

  p_exec_timing_r4: assert property (@(posedge clk) disable iff (!rstN)
    (csrAddr == A_CFG && csrRdata[2]) |-> !csrRdata[18]);

  p_watch_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !trigUpdated |-> $stable({watchFetch, watchLoad, watchStore}));

  p_pulse_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    trigUpdated |-> $past(csrWe && csrAddr == A_CFG));

  p_zero_reg_r9: assert property (@(posedge clk) disable iff (!rstN)
    (csrAddr == A_D3) |-> (csrRdata == '0));

endmodule

bind trig_bank trig_bank_chk #(.XLEN(XLEN), .NUM_TRIG(NUM_TRIG), .BASE_ADDR(BASE_ADDR)) u_chk (.*);

// File: tb/trig_bank_bench.sv
module trig_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;
  localparam int NT = 4;
  localparam logic [11:0] A_SEL = 12'h7A0, A_CFG = 12'h7A1,
                          A_D2 = 12'h7A2, A_D3 = 12'h7A3, A_OTHER = 12'h300;

  logic clk = 1'b0, rstN = 1'b0;
  logic [11:0] csrAddr = A_OTHER;
  logic [XLEN-1:0] csrWdata = '0;
  logic csrWe = 1'b0, debugMode = 1'b0;
  logic [XLEN-1:0] csrRdata;
  logic watchFetch, watchLoad, watchStore, trigUpdated;

  int checks = 0, errors = 0;
  bit finished = 0;
  int mSel = 0;
  logic [31:0] mCfg [NT];
  logic [31:0] mD2 [NT];

  always #(CLK_PERIOD/2) clk = ~clk;

  trig_bank u_trig_bank (.*);

  function automatic logic [31:0] expCfg(logic [31:0] w);
    logic [31:0] r;
    r = (w & 32'h080F_FFFF) | 32'h2000_0000;
    if (w[2]) r[18] = 1'b0;
    return r;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic readChk(logic [11:0] a, logic [31:0] exp, string req);
    csrAddr = a;
    #1;
    check(csrRdata === exp, req, csrRdata, exp);
  endtask

  task automatic flagChk();
    logic [2:0] e = 3'b000;
    for (int t = 0; t < NT; t++) e = e | {mCfg[t][2], mCfg[t][0], mCfg[t][1]};
    check({watchFetch, watchLoad, watchStore} === e, "R7 watch flags",
          32'({watchFetch, watchLoad, watchStore}), 32'(e));
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d, logic dbg);
    bit pulse = 0;
    bit open = !mCfg[mSel][27] || dbg;
    @(negedge clk);
    csrAddr = a; csrWdata = d; csrWe = 1'b1; debugMode = dbg;
    @(negedge clk);
    csrWe = 1'b0;
    if (a == A_SEL && d < NT) mSel = int'(d);
    if (a == A_CFG && open) begin mCfg[mSel] = expCfg(d); pulse = 1; end
    if (a == A_D2 && open) mD2[mSel] = d;
    check(trigUpdated === pulse, "R8 update pulse", 32'(trigUpdated), 32'(pulse));
    flagChk();
  endtask

  task automatic readAll(string tag);
    readChk(A_SEL, 32'(mSel), {"R2 select ", tag});
    readChk(A_CFG, mCfg[mSel], {"R3 R4 R5 R10 control ", tag});
    readChk(A_D2, mD2[mSel], {"R6 R5 R10 data ", tag});
    readChk(A_D3, 32'h0, {"R9 zero reg ", tag});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int t = 0; t < NT; t++) begin mCfg[t] = 32'h2000_0000; mD2[t] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state of every trigger
    check(trigUpdated === 1'b0, "R1 reset pulse", 32'(trigUpdated), 0);
    flagChk();
    for (int t = 0; t < NT; t++) begin
      if (t != 0) wr(A_SEL, 32'(t), 1'b0);
      readChk(A_CFG, 32'h2000_0000, "R1 reset control");
      readChk(A_D2, 32'h0, "R1 reset data");
    end
    wr(A_SEL, 32'd0, 1'b0);
    readChk(A_SEL, 32'h0, "R1 select");
    // R2 out-of-range selects dropped
    wr(A_SEL, 32'd2, 1'b0);
    wr(A_SEL, 32'd4, 1'b0);
    readChk(A_SEL, 32'd2, "R2 select 4 dropped");
    wr(A_SEL, 32'hFFFF_FFFF, 1'b0);
    readChk(A_SEL, 32'd2, "R2 select all-ones dropped");
    // R4 execute forces timing
    wr(A_CFG, 32'hFFFF_FFFF, 1'b1);
    readChk(A_CFG, 32'h280B_FFFF, "R4 timing forced");
    wr(A_CFG, 32'h0004_0002, 1'b1);
    readChk(A_CFG, 32'h2004_0002, "R3 timing kept without execute");
    // R5 lock
    wr(A_CFG, 32'h0800_0001, 1'b1);
    wr(A_CFG, 32'h0000_0004, 1'b0);
    readChk(A_CFG, 32'h2800_0001, "R5 locked control dropped");
    wr(A_D2, 32'hDEAD_BEEF, 1'b0);
    readChk(A_D2, 32'h0, "R5 locked data dropped");
    wr(A_D2, 32'h1234_5678, 1'b1);
    readChk(A_D2, 32'h1234_5678, "R6 data in debug mode");
    wr(A_CFG, 32'h0000_0000, 1'b1);
    readChk(A_CFG, 32'h2000_0000, "R5 unlock in debug mode");
    // R9 writes elsewhere ignored
    wr(A_D3, 32'hFFFF_FFFF, 1'b1);
    wr(A_OTHER, 32'hFFFF_FFFF, 1'b1);
    readChk(A_OTHER, 32'h0, "R9 other address");
    readAll("after ignored writes");
    // random mix
    for (int i = 0; i < 400; i++) begin
      int op = int'($urandom_range(0, 4));
      logic dbg = 1'($urandom_range(0, 1));
      case (op)
        0: wr(A_SEL, $urandom_range(0, 7), dbg);
        1, 2: wr(A_CFG, $urandom, dbg);
        3: wr(A_D2, $urandom, dbg);
        default: wr(A_D3, $urandom, dbg);
      endcase
      readAll("random");
    end
    for (int t = 0; t < NT; t++) begin
      wr(A_SEL, 32'(t), 1'b0);
      readAll("final sweep R10");
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule